// File: doc/BRIEF.md
# Dual-Bank GPIO Control Register File

This block holds the control and status state for sixteen general-purpose pins, split into two banks of eight. A bus slave in front of it presents a 4-bit register pointer, a write strobe with a data byte, and a read strobe. The block answers with the byte held at that pointer. On the pin side it takes the raw pin levels. It returns, per pin, an output value, an output enable, a pull-up request and a pull-down request. It also returns a bus-hold enable per bank and a single active-low interrupt.

Every per-pin register exists once per bank, and the two copies sit at adjacent addresses. Pointer bits [3:1] select the register kind and bit 0 selects the bank. Incoming pin levels pass through a two-stage synchronizer. They can be read back with a per-pin polarity flip. An unmasked pin whose level moves away from the value captured at the last read of its bank's input register pulls the interrupt low. Pad drivers, resistors and level shifting live outside. Only the control bits leave this block.

Top module: `pinbank_regs`

## Requirements
- R1: The pointer decodes as kind = addr[3:1] and bank = addr[0], giving the map below.
  - 0/1: input (read only).
  - 2/3: polarity.
  - 4/5: bank config. Bit 0 is the pull enable and bit 1 is the bus-hold enable. Bits 7:2 read 0.
  - 6/7: pull select.
  - 8/9: direction.
  - A/B: output.
  - C/D: interrupt mask.
  - E/F: reserved.
- R2: Direction bit 1 makes a pin an input and bit 0 makes it an output. The output enable equals the inverted direction bit. Direction registers reset to 8'hFF.
- R3: The output registers reset to 8'h00, and their value appears on pin_out. The value reaches the pad only where pin_oe is 1.
- R4: Reading an input register returns the synchronized pin level XOR the bank's polarity byte. A pin change becomes visible after two rising clock edges.
- R5: The polarity registers reset to 8'h00, which passes input data through unchanged.
- R6: The pull-select registers reset to 8'hFF (1 = pull-up, 0 = pull-down).
  - pull_up_en is the pull-select bit ANDed with the bank pull enable.
  - pull_dn_en is the inverted pull-select bit ANDed with the bank pull enable.
  - hold_en[b] is the bank bus-hold bit.
  - Both config bits reset to 0.
- R7: Writes to the input registers and to the reserved addresses E/F change nothing. Reserved addresses read 8'h00.
- R8: A synchronous rst high, or ext_rst_n low, at a rising edge returns every register to its default value.
- R9: The mask registers reset to 8'hFF (1 = masked). A masked pin never drives int_n low.
- R10: int_n is low while any unmasked pin's synchronized level differs from that bank's snapshot.
  - Snapshots reset to 0.
  - A snapshot is taken when rd_en is high at that bank's input address.
  - int_n returns high in the cycle after such a read if the pins hold still.
  - int_n also returns high when the pin goes back to its captured value.
  - Reading one bank's input register leaves the other bank's snapshot alone.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| ext_rst_n | input | 1 | External active-low reset, sampled synchronously |
| reg_addr | input | 4 | Register pointer |
| wr_en | input | 1 | Write strobe |
| wr_data | input | 8 | Write data |
| rd_en | input | 1 | Read strobe (takes the interrupt snapshot on input reads) |
| rd_data | output | 8 | Data at reg_addr |
| pin_in | input | 16 | Pin levels, bank b at bits [8b+7:8b] |
| pin_out | output | 16 | Output register values |
| pin_oe | output | 16 | Output enables |
| pull_up_en | output | 16 | Pull-up request per pin |
| pull_dn_en | output | 16 | Pull-down request per pin |
| hold_en | output | 2 | Bus-hold enable per bank |
| int_n | output | 1 | Active-low interrupt |

## Verification
The embedded assertions check several properties on every cycle:
- the reset values seen on the pin-side outputs;
- the output latch staying still when no output write reaches it;
- a fully masked bank never raising an interrupt;
- a snapshot read with settled pins clearing that bank's interrupt on the next cycle;
- reserved addresses reading zero.

Only the bench scenarios can show the rest:
- the register map and read-back values;
- the two-edge synchronizer latency;
- polarity inversion;
- the pull-up/pull-down gating by the bank enable;
- writes to read-only locations being ignored;
- an interrupt returning when a pin goes back to its snapshot;
- the per-bank independence of snapshots.

// File: rtl/pinbank_pkg.sv
`timescale 1ns/1ps
package pinbank_pkg;
    localparam int BANK_W     = 8;
    localparam int NUM_BANKS  = 2;
    localparam int ADDR_W     = 4;
    localparam int BANK_IDX_W = (NUM_BANKS > 1) ? $clog2(NUM_BANKS) : 1;
    localparam int KIND_W     = ADDR_W - BANK_IDX_W;
    localparam int PINS       = NUM_BANKS * BANK_W;

    typedef enum logic [KIND_W-1:0] {
        K_INPUT = 3'd0,
        K_POLAR = 3'd1,
        K_CFG   = 3'd2,
        K_PSEL  = 3'd3,
        K_DIR   = 3'd4,
        K_OUT   = 3'd5,
        K_MASK  = 3'd6,
        K_RSVD  = 3'd7
    } reg_kind_e;

    typedef struct packed {
        logic hold_en;
        logic pull_en;
    } bank_cfg_t;

    typedef struct packed {
        reg_kind_e              kind;
        logic [BANK_IDX_W-1:0]  bank;
    } reg_sel_t;

    typedef struct packed {
        logic [BANK_W-1:0] pol;
        logic [BANK_W-1:0] psel;
        logic [BANK_W-1:0] dir;
        logic [BANK_W-1:0] outv;
        logic [BANK_W-1:0] mask;
        logic [BANK_W-1:0] snap;
        bank_cfg_t         cfg;
    } bank_state_t;

    localparam bank_state_t BANK_RESET = '{
        pol:  '0,
        psel: '1,
        dir:  '1,
        outv: '0,
        mask: '1,
        snap: '0,
        cfg:  '{hold_en: 1'b0, pull_en: 1'b0}
    };

    function automatic reg_sel_t decode_addr(input logic [ADDR_W-1:0] a);
        reg_sel_t s;
        s.kind = reg_kind_e'(a[ADDR_W-1:BANK_IDX_W]);
        s.bank = a[BANK_IDX_W-1:0];
        return s;
    endfunction

    function automatic logic [BANK_W-1:0] cfg_to_byte(input bank_cfg_t c);
        logic [BANK_W-1:0] r;
        r = '0;
        r[1] = c.hold_en;
        r[0] = c.pull_en;
        return r;
    endfunction

    function automatic bank_cfg_t byte_to_cfg(input logic [BANK_W-1:0] b);
        bank_cfg_t c;
        c.hold_en = b[1];
        c.pull_en = b[0];
        return c;
    endfunction

    function automatic logic writable(input reg_kind_e k);
        return (k != K_INPUT) && (k != K_RSVD);
    endfunction
endpackage

// File: rtl/pinbank_sync.sv
`timescale 1ns/1ps
module pinbank_sync #(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [W-1:0] d,
    output logic [W-1:0] q_meta,
    output logic [W-1:0] q
);
    always_ff @(posedge clk) begin
        if (rst) begin
            q_meta <= '0;
            q      <= '0;
        end else begin
            q_meta <= d;
            q      <= q_meta;
        end
    end
endmodule

// File: rtl/pinbank_bank.sv
`timescale 1ns/1ps
module pinbank_bank
    import pinbank_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              wr_en,
    input  reg_kind_e         wr_kind,
    input  logic [BANK_W-1:0] wr_data,
    input  reg_kind_e         rd_kind,
    output logic [BANK_W-1:0] rd_data,
    input  logic              capture,
    input  logic [BANK_W-1:0] pin_in,
    output logic [BANK_W-1:0] pin_out,
    output logic [BANK_W-1:0] pin_oe,
    output logic [BANK_W-1:0] pull_up_en,
    output logic [BANK_W-1:0] pull_dn_en,
    output logic              hold_en,
    output logic              irq
);
    bank_state_t       st_q, st_d;
    logic [BANK_W-1:0] lvl_meta, lvl;
    logic              out_wr;

    pinbank_sync #(.W(BANK_W)) u_sync (
        .clk    (clk),
        .rst    (rst),
        .d      (pin_in),
        .q_meta (lvl_meta),
        .q      (lvl)
    );

    assign out_wr = wr_en && (wr_kind == K_OUT);

    always_comb begin
        st_d = st_q;
        if (wr_en) begin
            case (wr_kind)
                K_POLAR: st_d.pol  = wr_data;
                K_CFG:   st_d.cfg  = byte_to_cfg(wr_data);
                K_PSEL:  st_d.psel = wr_data;
                K_DIR:   st_d.dir  = wr_data;
                K_OUT:   st_d.outv = wr_data;
                K_MASK:  st_d.mask = wr_data;
                default: ;
            endcase
        end
        if (capture) st_d.snap = lvl;
    end

    always_ff @(posedge clk) begin
        if (rst) st_q <= BANK_RESET;
        else     st_q <= st_d;
    end

    always_comb begin
        case (rd_kind)
            K_INPUT: rd_data = lvl ^ st_q.pol;
            K_POLAR: rd_data = st_q.pol;
            K_CFG:   rd_data = cfg_to_byte(st_q.cfg);
            K_PSEL:  rd_data = st_q.psel;
            K_DIR:   rd_data = st_q.dir;
            K_OUT:   rd_data = st_q.outv;
            K_MASK:  rd_data = st_q.mask;
            default: rd_data = '0;
        endcase
    end

    assign pin_out    = st_q.outv;
    assign pin_oe     = ~st_q.dir;
    assign pull_up_en = {BANK_W{st_q.cfg.pull_en}} & st_q.psel;
    assign pull_dn_en = {BANK_W{st_q.cfg.pull_en}} & ~st_q.psel;
    assign hold_en    = st_q.cfg.hold_en;
    assign irq        = |((lvl ^ st_q.snap) & ~st_q.mask);

    // R8: defaults on the pin side right after reset
    assert_reset_state_R8: assert property (@(posedge clk)
        $past(rst) |-> (pin_oe == '0) && (pin_out == '0) && !hold_en
                       && (pull_up_en == '0) && (pull_dn_en == '0));

    // R3: output latch only moves on an output write
    assert_out_hold_R3: assert property (@(posedge clk) disable iff (rst)
        !out_wr |=> $stable(pin_out));

    // R9: a fully masked bank cannot interrupt
    assert_mask_quiet_R9: assert property (@(posedge clk) disable iff (rst)
        (st_q.mask == '1) |-> !irq);

    // R10: a snapshot with settled pins clears the request
    assert_read_clears_R10: assert property (@(posedge clk) disable iff (rst)
        (capture && (lvl_meta == lvl) && !wr_en) |=> !irq);
endmodule

// File: rtl/pinbank_regs.sv
`timescale 1ns/1ps
module pinbank_regs
    import pinbank_pkg::*;
(
    input  logic                 clk,
    input  logic                 rst,
    input  logic                 ext_rst_n,
    input  logic [ADDR_W-1:0]    reg_addr,
    input  logic                 wr_en,
    input  logic [BANK_W-1:0]    wr_data,
    input  logic                 rd_en,
    output logic [BANK_W-1:0]    rd_data,
    input  logic [PINS-1:0]      pin_in,
    output logic [PINS-1:0]      pin_out,
    output logic [PINS-1:0]      pin_oe,
    output logic [PINS-1:0]      pull_up_en,
    output logic [PINS-1:0]      pull_dn_en,
    output logic [NUM_BANKS-1:0] hold_en,
    output logic                 int_n
);
    logic                 rst_all;
    reg_sel_t             sel;
    logic [BANK_W-1:0]    bank_rd [NUM_BANKS];
    logic [NUM_BANKS-1:0] bank_irq;

    assign rst_all = rst | ~ext_rst_n;
    assign sel     = decode_addr(reg_addr);

    for (genvar b = 0; b < NUM_BANKS; b++) begin : g_bank
        logic hit;
        assign hit = (sel.bank == BANK_IDX_W'(b));

        pinbank_bank u_bank (
            .clk        (clk),
            .rst        (rst_all),
            .wr_en      (wr_en && hit && writable(sel.kind)),
            .wr_kind    (sel.kind),
            .wr_data    (wr_data),
            .rd_kind    (sel.kind),
            .rd_data    (bank_rd[b]),
            .capture    (rd_en && hit && (sel.kind == K_INPUT)),
            .pin_in     (pin_in[b*BANK_W +: BANK_W]),
            .pin_out    (pin_out[b*BANK_W +: BANK_W]),
            .pin_oe     (pin_oe[b*BANK_W +: BANK_W]),
            .pull_up_en (pull_up_en[b*BANK_W +: BANK_W]),
            .pull_dn_en (pull_dn_en[b*BANK_W +: BANK_W]),
            .hold_en    (hold_en[b]),
            .irq        (bank_irq[b])
        );
    end

    assign rd_data = bank_rd[sel.bank];
    assign int_n   = ~|bank_irq;

    // R7: reserved locations read zero
    assert_rsvd_zero_R7: assert property (@(posedge clk) disable iff (rst_all)
        (sel.kind == K_RSVD) |-> (rd_data == '0));
endmodule

// File: tb/tb_pinbank_regs.sv
`timescale 1ns/1ps
module tb_pinbank_regs;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        ext_rst_n = 1'b1;
    logic [3:0]  reg_addr = '0;
    logic        wr_en = 1'b0;
    logic [7:0]  wr_data = '0;
    logic        rd_en = 1'b0;
    logic [7:0]  rd_data;
    logic [15:0] pin_in = '0;
    logic [15:0] pin_out, pin_oe, pull_up_en, pull_dn_en;
    logic [1:0]  hold_en;
    logic        int_n;

    int n_cmp = 0;
    int n_bad = 0;

    always #4 clk = ~clk;

    pinbank_regs dut (
        .clk(clk), .rst(rst), .ext_rst_n(ext_rst_n), .reg_addr(reg_addr),
        .wr_en(wr_en), .wr_data(wr_data), .rd_en(rd_en), .rd_data(rd_data),
        .pin_in(pin_in), .pin_out(pin_out), .pin_oe(pin_oe),
        .pull_up_en(pull_up_en), .pull_dn_en(pull_dn_en),
        .hold_en(hold_en), .int_n(int_n)
    );

    task automatic check(input string req, input string what,
                         input logic [31:0] act, input logic [31:0] exp);
        n_cmp++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
        end
    endtask

    task automatic wr(input logic [3:0] a, input logic [7:0] d);
        @(negedge clk);
        reg_addr = a; wr_data = d; wr_en = 1'b1;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic rd(input logic [3:0] a, input logic cap, output logic [7:0] v);
        @(negedge clk);
        reg_addr = a; rd_en = cap;
        #1 v = rd_data;
        @(negedge clk);
        rd_en = 1'b0;
    endtask

    task automatic set_pins(input logic [15:0] v);
        @(negedge clk);
        pin_in = v;
        repeat (2) @(negedge clk);
    endtask

    task automatic do_reset();
        @(negedge clk);
        pin_in = '0; rst = 1'b1;
        @(negedge clk);
        rst = 1'b0;
        repeat (2) @(negedge clk);
    endtask

    task automatic t_reset_defaults();
        logic [7:0] v;
        do_reset();
        rd(4'h0, 0, v); check("R4", "input0", v, 8'h00);
        rd(4'h2, 0, v); check("R5", "polarity0", v, 8'h00);
        rd(4'h3, 0, v); check("R5", "polarity1", v, 8'h00);
        rd(4'h4, 0, v); check("R6", "cfg0", v, 8'h00);
        rd(4'h7, 0, v); check("R6", "psel1", v, 8'hFF);
        rd(4'h8, 0, v); check("R2", "dir0", v, 8'hFF);
        rd(4'h9, 0, v); check("R2", "dir1", v, 8'hFF);
        rd(4'hB, 0, v); check("R3", "out1", v, 8'h00);
        rd(4'hC, 0, v); check("R9", "mask0", v, 8'hFF);
        rd(4'hD, 0, v); check("R9", "mask1", v, 8'hFF);
        check("R8", "pin_oe", pin_oe, 16'h0000);
        check("R8", "pin_out", pin_out, 16'h0000);
        check("R8", "pulls", {pull_up_en, pull_dn_en}, 32'h0);
        check("R8", "hold_en", hold_en, 2'b00);
        check("R10", "int_n", int_n, 1'b1);
    endtask

    task automatic t_direction_output();
        logic [7:0] v;
        do_reset();
        wr(4'h8, 8'h0F); wr(4'hA, 8'hA5);
        wr(4'h9, 8'hF0); wr(4'hB, 8'h3C);
        check("R2", "pin_oe", pin_oe, 16'h0FF0);
        check("R3", "pin_out", pin_out, 16'h3CA5);
        rd(4'h9, 0, v); check("R1", "dir1 readback", v, 8'hF0);
        rd(4'hA, 0, v); check("R1", "out0 readback", v, 8'hA5);
    endtask

    task automatic t_input_polarity();
        logic [7:0] v;
        do_reset();
        @(negedge clk); pin_in = 16'h1234;
        @(negedge clk);
        reg_addr = 4'h0; #1 check("R4", "after one edge", rd_data, 8'h00);
        @(negedge clk);
        reg_addr = 4'h0; #1 check("R4", "after two edges", rd_data, 8'h34);
        rd(4'h1, 0, v); check("R4", "input1", v, 8'h12);
        wr(4'h2, 8'hFF);
        rd(4'h0, 0, v); check("R4", "input0 inverted", v, 8'hCB);
        wr(4'h3, 8'h0F);
        rd(4'h1, 0, v); check("R4", "input1 part inverted", v, 8'h1D);
    endtask

    task automatic t_readonly();
        logic [7:0] v;
        do_reset();
        set_pins(16'h00C3);
        wr(4'h0, 8'hFF);
        rd(4'h0, 0, v); check("R7", "input0 after write", v, 8'hC3);
        wr(4'hE, 8'hFF); wr(4'hF, 8'h55);
        rd(4'hE, 0, v); check("R7", "rsvd E", v, 8'h00);
        rd(4'hF, 0, v); check("R7", "rsvd F", v, 8'h00);
        rd(4'h8, 0, v); check("R7", "dir0 untouched", v, 8'hFF);
        rd(4'h2, 0, v); check("R7", "pol0 untouched", v, 8'h00);
        check("R7", "pin_out untouched", pin_out, 16'h0000);
    endtask

    task automatic t_pull();
        logic [7:0] v;
        do_reset();
        wr(4'h6, 8'h0F);
        check("R6", "no pull when disabled", {pull_up_en, pull_dn_en}, 32'h0);
        wr(4'h4, 8'h01);
        check("R6", "pull_up bank0", pull_up_en, 16'h000F);
        check("R6", "pull_dn bank0", pull_dn_en, 16'h00F0);
        wr(4'h5, 8'h02);
        check("R6", "hold bank1", hold_en, 2'b10);
        check("R6", "bank1 pulls off", {pull_up_en[15:8], pull_dn_en[15:8]}, 16'h0);
        wr(4'h5, 8'hFF);
        rd(4'h5, 0, v); check("R6", "cfg1 readback", v, 8'h03);
        check("R6", "bank1 pull_up default", pull_up_en[15:8], 8'hFF);
    endtask

    task automatic t_interrupt();
        logic [7:0] v;
        do_reset();
        set_pins(16'h0002);
        check("R9", "masked change quiet", int_n, 1'b1);
        wr(4'hC, 8'hFE);
        rd(4'h0, 1, v);
        set_pins(16'h0003);
        check("R10", "unmasked change", int_n, 1'b0);
        rd(4'h0, 1, v);
        check("R10", "read clears", int_n, 1'b1);
        set_pins(16'h0002);
        check("R10", "differs from snapshot", int_n, 1'b0);
        set_pins(16'h0003);
        check("R10", "back to snapshot", int_n, 1'b1);
        wr(4'hD, 8'h7F);
        set_pins(16'h8003);
        check("R10", "bank1 change", int_n, 1'b0);
        rd(4'h0, 1, v);
        check("R10", "bank0 read leaves bank1", int_n, 1'b0);
        rd(4'h1, 1, v);
        check("R10", "bank1 read clears", int_n, 1'b1);
        set_pins(16'h0003);
        check("R10", "bank1 pending again", int_n, 1'b0);
        wr(4'hD, 8'hFF);
        check("R9", "remask silences", int_n, 1'b1);
    endtask

    task automatic t_ext_reset();
        logic [7:0] v;
        do_reset();
        wr(4'h8, 8'h00); wr(4'hB, 8'h77); wr(4'h4, 8'h03);
        @(negedge clk); ext_rst_n = 1'b0;
        @(negedge clk); ext_rst_n = 1'b1;
        check("R8", "oe after ext reset", pin_oe, 16'h0000);
        check("R8", "out after ext reset", pin_out, 16'h0000);
        check("R8", "hold after ext reset", hold_en, 2'b00);
        rd(4'h4, 0, v); check("R8", "cfg0 after ext reset", v, 8'h00);
    endtask

    initial begin
        #(8 * 150000);
        n_bad++;
        $display("FAIL watchdog: all requirements, actual timeout expected completion");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

    initial begin
        t_reset_defaults();
        t_direction_output();
        t_input_polarity();
        t_readonly();
        t_pull();
        t_interrupt();
        t_ext_reset();
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end
endmodule